// File: doc/BRIEF.md
# Receive link alarm and interrupt register

This block keeps the alarm state for one receive port of a serial link disassembler and turns it into a single interrupt. It watches three inputs. The first is the trace label byte recovered from the link. The second is an expected label that the processor programs. The third is a set of three live loss-of-lock indications, one each for the descrambler, the container delineation and the frame delineation. From these it latches sticky alarm bits for a label change, a label mismatch and a change in lock status. It also keeps a sticky copy of each loss-of-lock indication.

The processor reaches the block through a plain strobe interface with a 2-bit address. It can read the alarm register, and that read clears the sticky bits. It can read and write an interrupt-enable register and the expected label, and it can read the stored received label. A bit called "message ready" sits at the bottom of the alarm register. An input pulse from the mailbox logic sets it, and the processor clears it by writing.

The interrupt is one registered, level-sensitive output. It is high whenever any alarm bit is set together with its enable bit.

Top module: `link_alarm_irq`

## Requirements
- R1: After reset, the alarm register, the enable register, the expected label, the stored label and `irq` are all 0.
- R2: The register map has four addresses. Address 0 is the alarm register and address 1 is the interrupt enable. Address 2 is the expected label. Address 3 is the stored received label, which is read-only, so writes to it have no effect. `rd_data` shows the addressed register in the same cycle.
- R3: The stored label is the `rx_label` value captured at each clock edge. Alarm bit 5 (label mismatch) is set at the edge after a cycle in which the stored label differs from the expected label.
- R4: Alarm bit 6 (label change) is set at the edge after a cycle in which `rx_label` differs from the stored label. No change is reported at the first edge after reset.
- R5: Alarm bit 4 (status change) is set at the edge after a cycle in which any `oolock` bit differs from its value at the previous edge. Changes in both directions count. No change is reported at the first edge after reset.
- R6: Alarm bits 3, 2 and 1 are sticky copies of `oolock[2]` (descrambler), `oolock[1]` (container delineation) and `oolock[0]` (frame delineation). A 1 means out of lock. While the condition holds, the bit is set again at every edge.
- R7: A read of address 0 (`rd_en` high) clears alarm bits 6 to 1 at the next edge. Bit 0 is not affected. If a set event for a bit falls in the same cycle as the clearing read, the bit stays set.
- R8: Alarm bit 0 (message ready) is set by a `msg_ready` pulse. A write to address 0 loads bit 0 from `wr_data[0]`, and the write ignores the other bits. If a write and a `msg_ready` pulse fall in the same cycle, the set wins.
- R9: The enable register uses the same bit layout as the alarm register. A 1 enables the bit. Bit 7 of the enable register always reads 0.
- R10: `irq` is set one edge after a cycle in which any of bits 6 to 0 of the alarm register is set together with its enable bit. It is low one edge after a cycle in which there is no such pair.
- R11: Bit 7 of the alarm register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_label | input | 8 | Received trace label byte |
| oolock | input | 3 | Loss-of-lock indications: [2] descrambler, [1] container, [0] frame (1 = out of lock) |
| msg_ready | input | 1 | Pulse that sets alarm bit 0 |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a read of address 0 clears the sticky bits |
| rd_data | output | 8 | Read data for the addressed register |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a set event that falls in the same cycle as a clearing read or a write to bit 0. Only these cases show whether the set wins. To reach them, the stimulus issues the read strobe in the very cycle where it changes `rx_label` or toggles a lock bit, and in the cycle where it pulses `msg_ready` together with a write. A behavioural model in the bench is compared against the outputs at every clock, including across the first edge after reset, where edge events must stay quiet.

// File: rtl/link_alarm_pkg.sv
package link_alarm_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned LOCK_N = 3;

  typedef enum logic [1:0] {
    SEL_ALARM  = 2'd0,
    SEL_IRQEN  = 2'd1,
    SEL_EXPECT = 2'd2,
    SEL_LABEL  = 2'd3
  } reg_sel_e;

  localparam int unsigned B_LCHG = 6;
  localparam int unsigned B_LMIS = 5;
  localparam int unsigned B_COS  = 4;
  localparam int unsigned B_LOCK = 1; // bits 3:1 hold the lock copies
  localparam int unsigned B_MSG  = 0;

  // sticky update: a set in the same cycle beats a clear
  function automatic logic [REG_W-1:0] sticky_next(
      input logic [REG_W-1:0] cur,
      input logic [REG_W-1:0] set,
      input logic [REG_W-1:0] clr);
    return set | (cur & ~clr);
  endfunction

  // any alarm bit (6:0) paired with its enable
  function automatic logic gated_any(
      input logic [REG_W-1:0] alarm,
      input logic [REG_W-1:0] en);
    return |(alarm[REG_W-2:0] & en[REG_W-2:0]);
  endfunction
endpackage

// File: rtl/lbl_watch.sv
module lbl_watch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_label,
  input  logic [W-1:0] exp_label,
  output logic [W-1:0] lbl_q,
  output logic         chg_ev,
  output logic         mis_ev
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      lbl_q   <= rx_label;
      armed_q <= 1'b1;
    end
  end

  assign chg_ev = armed_q && (rx_label != lbl_q);
  assign mis_ev = (lbl_q != exp_label);
endmodule

// File: rtl/lock_watch.sv
module lock_watch #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lock_in,
  output logic         cos_ev
);
  logic [N-1:0] lock_q;
  logic         armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      lock_q  <= lock_in;
      armed_q <= 1'b1;
    end
  end

  assign cos_ev = armed_q && (lock_in != lock_q);
endmodule

// File: rtl/alarm_bank.sv
module alarm_bank
  import link_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic             rd_clr,
  input  logic             wr_bit0,
  input  logic             wr_val0,
  output logic [REG_W-1:0] alarm_q
);
  logic [REG_W-1:0] clr_vec;

  generate
    for (genvar i = 0; i < REG_W; i++) begin : g_clr
      if (i == B_MSG) begin : g_msg
        assign clr_vec[i] = wr_bit0 && !wr_val0;
      end else begin : g_ro
        assign clr_vec[i] = rd_clr;
      end
    end
  endgenerate

  logic [REG_W-1:0] set_all;
  always_comb begin
    set_all = set_vec;
    set_all[B_MSG] = set_vec[B_MSG] | (wr_bit0 & wr_val0);
    set_all[REG_W-1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= '0;
    else        alarm_q <= sticky_next(alarm_q, set_all, clr_vec);
  end
endmodule

// File: rtl/link_alarm_irq.sv
module link_alarm_irq
  import link_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_label,
  input  logic [2:0]        oolock,
  input  logic              msg_ready,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam logic [REG_W-1:0] EN_MASK = {1'b0, {(REG_W-1){1'b1}}};

  logic [DATA_W-1:0] exp_q, lbl_q;
  logic [REG_W-1:0]  en_q, alarm_q, set_vec;
  logic              lbl_chg_ev, lbl_mis_ev, cos_ev, rd_alarm, wr_alarm;

  lbl_watch #(.W(DATA_W)) u_lbl (
    .clk(clk), .rst_n(rst_n), .rx_label(rx_label), .exp_label(exp_q),
    .lbl_q(lbl_q), .chg_ev(lbl_chg_ev), .mis_ev(lbl_mis_ev)
  );

  lock_watch #(.N(LOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .lock_in(oolock), .cos_ev(cos_ev)
  );

  assign rd_alarm = rd_en && (reg_sel_e'(addr) == SEL_ALARM);
  assign wr_alarm = wr_en && (reg_sel_e'(addr) == SEL_ALARM);

  always_comb begin
    set_vec = '0;
    set_vec[B_LCHG] = lbl_chg_ev;
    set_vec[B_LMIS] = lbl_mis_ev;
    set_vec[B_COS]  = cos_ev;
    set_vec[B_LOCK +: LOCK_N] = oolock;
    set_vec[B_MSG]  = msg_ready;
  end

  alarm_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_clr(rd_alarm),
    .wr_bit0(wr_alarm), .wr_val0(wr_data[0]), .alarm_q(alarm_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      exp_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_en && reg_sel_e'(addr) == SEL_IRQEN)  en_q  <= wr_data & EN_MASK;
      if (wr_en && reg_sel_e'(addr) == SEL_EXPECT) exp_q <= wr_data;
      irq <= gated_any(alarm_q, en_q);
    end
  end

  always_comb begin
    unique case (reg_sel_e'(addr))
      SEL_ALARM:  rd_data = alarm_q;
      SEL_IRQEN:  rd_data = en_q;
      SEL_EXPECT: rd_data = exp_q;
      SEL_LABEL:  rd_data = lbl_q;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/link_alarm_chk.sv
module link_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_alarm,
  input logic       lbl_chg_ev,
  input logic       lbl_mis_ev,
  input logic       cos_ev,
  input logic [2:0] oolock,
  input logic       msg_ready,
  input logic [7:0] alarm_q,
  input logic [7:0] en_q,
  input logic       irq
);
  assert_mis_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_mis_ev |=> alarm_q[5]);
  assert_chg_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_chg_ev |=> alarm_q[6]);
  assert_cos_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cos_ev |=> alarm_q[4]);
  assert_lock_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oolock[2] |=> alarm_q[3]);
  assert_rd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_alarm && !lbl_chg_ev) |=> !alarm_q[6]);
  assert_msg_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |=> alarm_q[0]);
  assert_irq_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(alarm_q[6:0] & en_q[6:0])) |=> irq);
  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(alarm_q[6:0] & en_q[6:0])) |=> !irq);
endmodule

bind link_alarm_irq link_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_alarm(rd_alarm), .lbl_chg_ev(lbl_chg_ev),
  .lbl_mis_ev(lbl_mis_ev), .cos_ev(cos_ev), .oolock(oolock),
  .msg_ready(msg_ready), .alarm_q(alarm_q), .en_q(en_q), .irq(irq)
);

// File: tb/link_alarm_irq_bench.sv
module link_alarm_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_label = 8'h00;
  logic [2:0] oolock = 3'b000;
  logic       msg_ready = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  link_alarm_irq u_link_alarm_irq (
    .clk(clk), .rst_n(rst_n), .rx_label(rx_label), .oolock(oolock),
    .msg_ready(msg_ready), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  // behavioural reference model
  int m_alarm, m_en, m_exp, m_lbl, m_lock, m_irq;
  bit m_armed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_alarm = 0; m_en = 0; m_exp = 0; m_lbl = 0; m_lock = 0; m_irq = 0; m_armed = 0;
    end else begin
      int nxt;
      int setm;
      setm = 0;
      if (m_armed && rx_label != m_lbl) setm += 64;       // R4
      if (m_lbl != m_exp) setm += 32;                      // R3
      if (m_armed && oolock != m_lock) setm += 16;         // R5
      setm += oolock * 2;                                  // R6
      nxt = m_alarm;
      if (rd_en && addr == 0) nxt = nxt % 2;               // R7
      if (wr_en && addr == 0) nxt = (nxt / 2) * 2 + wr_data[0]; // R8
      nxt = nxt | setm;
      if (msg_ready) nxt = nxt | 1;
      m_irq = ((m_alarm & m_en & 127) != 0) ? 1 : 0;       // R10
      if (wr_en && addr == 1) m_en = wr_data % 128;        // R9
      if (wr_en && addr == 2) m_exp = wr_data;
      m_alarm = nxt;
      m_lbl = rx_label;
      m_lock = oolock;
      m_armed = 1;
    end
  end

  always @(negedge clk) begin
    int exp_rd;
    #3;
    case (addr)
      2'd0: exp_rd = m_alarm;
      2'd1: exp_rd = m_en;
      2'd2: exp_rd = m_exp;
      default: exp_rd = m_lbl;
    endcase
    checks++;
    if (int'(rd_data) != exp_rd) begin
      fails++;
      $display("FAIL %s rd_data addr=%0d actual=%02h expected=%02h", cur_req, addr, rd_data, exp_rd);
    end
    checks++;
    if (int'(irq) != m_irq) begin
      fails++;
      $display("FAIL %s irq actual=%0d expected=%0d", cur_req, irq, m_irq);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state, all addresses, including the first edges after reset
    rx_label = 8'h3C; oolock = 3'b000;
    cyc(3);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin @(negedge clk); addr = a[1:0]; end
    rd(2'd0);
    // R2: address 3 is read-only
    cur_req = "R2";
    wr(2'd3, 8'hFF); addr = 2'd3; cyc(2);
    // R9: enable register bit 7 masked
    cur_req = "R9";
    wr(2'd1, 8'hFF); addr = 2'd1; cyc(1);
    // R3: mismatch vs expected label
    cur_req = "R3";
    wr(2'd2, 8'h3C); rd(2'd0); addr = 2'd0; cyc(3);
    rd(2'd0); cyc(2);
    @(negedge clk); rx_label = 8'h5A; cyc(3);
    // R4: change; R7: read in the same cycle as a change keeps bit 6
    cur_req = "R4";
    rd(2'd0); cyc(2);
    cur_req = "R7";
    @(negedge clk); rx_label = 8'h11; addr = 2'd0; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; cyc(2);
    rd(2'd0); cyc(1);
    // R5/R6: lock changes in both directions
    cur_req = "R5";
    @(negedge clk); oolock = 3'b100; cyc(3);
    cur_req = "R6";
    rd(2'd0); cyc(2);
    @(negedge clk); oolock = 3'b011; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; cyc(2);
    @(negedge clk); oolock = 3'b000; cyc(2);
    rd(2'd0); rd(2'd0); cyc(2);
    // R8: message ready bit, write semantics, set beats write of 0
    cur_req = "R8";
    @(negedge clk); msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0; cyc(2);
    rd(2'd0); cyc(1);
    wr(2'd0, 8'hFE); cyc(2);
    wr(2'd0, 8'h01); cyc(2);
    @(negedge clk); addr = 2'd0; wr_data = 8'h00; wr_en = 1'b1; msg_ready = 1'b1;
    @(negedge clk); wr_en = 1'b0; msg_ready = 1'b0; cyc(2);
    wr(2'd0, 8'h00); cyc(2);
    // R10: enable gating of irq, single bits
    cur_req = "R10";
    wr(2'd1, 8'h00); cyc(3);
    wr(2'd1, 8'h01); cyc(2);
    @(negedge clk); msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0; cyc(3);
    wr(2'd0, 8'h00); cyc(3);
    wr(2'd1, 8'h08); @(negedge clk); oolock = 3'b100; cyc(3);
    @(negedge clk); oolock = 3'b000; rd(2'd0); cyc(3);
    wr(2'd1, 8'h20); wr(2'd2, 8'h99); cyc(3);
    wr(2'd2, 8'h11); rd(2'd0); cyc(3);
    // R11: bit 7 of alarm after every source fires
    cur_req = "R11";
    wr(2'd1, 8'h7F);
    @(negedge clk); rx_label = 8'hE7; oolock = 3'b111; msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0; addr = 2'd0; cyc(3);
    @(negedge clk); oolock = 3'b000; rx_label = 8'h11; cyc(2);
    rd(2'd0); cyc(3);
    finish_run();
  end
endmodule